// File: doc/BRIEF.md
# Interrupt Status Register for a Flash Controller

This block holds the interrupt state of a flash memory controller in one 16-bit word that software reads and writes. Four source bits record that a read/load, a write, an erase or a reset sequence has finished. A master bit summarises them and drives the external interrupt pin, whose active level software selects. The operation sequencer reports finished work in two ways. It raises per-source strobes, and it presents the opcode of each command that completes, which the block decodes on its own.

Software acknowledges an interrupt by writing 0 to a bit. A write of 1 leaves the bit as it is. When auto mode is on, any write to the command register clears the whole word, so each new command starts with a clean status. Cold and warm/hot reset requests each load their own default word. All state changes on one clock.

Top module: `irq_status_reg`

## Requirements
- R1: After `rst_n` is released, or in the cycle after `cold_rst_i` is high, `rd_data_o` reads 16'h8080 (INT=1, RI=1).
- R2: In the cycle after `warm_rst_i` is high with `cold_rst_i` low, `rd_data_o` reads 16'h8010 (INT=1, RSTI=1). When both requests are high, the cold default applies.
- R3: Bit positions are INT=15, RI=7, WI=6, EI=5, RSTI=4. `src_evt_i[3]`, `[2]`, `[1]` and `[0]` set RI, WI, EI and RSTI respectively. A strobe sets its source bit and INT in the following cycle.
- R4: A completed command (`cmd_done_vld_i`=1) with opcode 16'h0000, 16'h000A, 16'h000C, 16'h000E or 16'h0013 sets RI and INT in the following cycle.
- R5: A completed command with opcode 16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0065 or 16'h0071 sets INT only. Any other opcode changes nothing, and an opcode with `cmd_done_vld_i`=0 changes nothing.
- R6: A register write (`reg_wr_en_i`) clears each of the five bits whose data bit is 0 and leaves each bit whose data bit is 1 unchanged. Bits 14..8 and 3..0 always read 0.
- R7: A command write (`cmd_wr_i`) with `auto_mode_i`=1 clears all bits. With `auto_mode_i`=0 a command write has no effect.
- R8: When a set event and a clear event (register write of 0 or auto-mode command write) reach the same bit in one cycle, the bit ends up 1.
- R9: `int_pin_o` equals `pol_i` while INT is 1 and equals the inverse of `pol_i` while INT is 0.
- R10: A reset request takes priority over source strobes, opcode completions and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads the cold default |
| src_evt_i | input | 4 | Completion strobes {RI, WI, EI, RSTI} |
| cmd_done_vld_i | input | 1 | A command completed this cycle |
| cmd_done_op_i | input | 16 | Opcode of the completed command |
| reg_wr_en_i | input | 1 | Software write to this register |
| reg_wr_data_i | input | 16 | Software write data |
| cmd_wr_i | input | 1 | Software write to the command register |
| auto_mode_i | input | 1 | Auto-clear mode enable |
| pol_i | input | 1 | Interrupt pin active level |
| cold_rst_i | input | 1 | Cold reset request |
| warm_rst_i | input | 1 | Warm or hot reset request |
| rd_data_o | output | 16 | Register read value |
| int_pin_o | output | 1 | External interrupt pin |

## Verification
The bench goes after the collisions between set and clear. If a clear were given priority, a completion arriving together with an acknowledge write or an auto-mode command write would be lost. It sweeps every decoded opcode and some neighbours, because a decoder that mixed up the load class and the master class would raise INT without RI or set RI wrongly. It checks that writes of 1 and reserved-field writes are ignored, that cold beats warm when both are requested, and that the pin follows both polarities; a swapped inversion shows up as a pin stuck at the wrong idle level.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    parameter int unsigned REG_W  = 16;
    parameter int unsigned OP_W   = 16;
    parameter int unsigned NSRC   = 4;

    // bit positions in the read word
    parameter int unsigned POS_INT  = 15;
    parameter int unsigned POS_SRC0 = 4;   // RSTI at 4, EI 5, WI 6, RI 7

    // source indices
    parameter int unsigned SRC_RST  = 0;
    parameter int unsigned SRC_ERS  = 1;
    parameter int unsigned SRC_WR   = 2;
    parameter int unsigned SRC_RD   = 3;

    typedef struct packed {
        logic            int_b;
        logic [NSRC-1:0] src;
    } irq_state_t;

    parameter irq_state_t COLD_DEF = '{int_b: 1'b1, src: 4'b1000};
    parameter irq_state_t WARM_DEF = '{int_b: 1'b1, src: 4'b0001};

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import irq_status_pkg::*;
(
    input  logic            vld_i,
    input  logic [OP_W-1:0] op_i,
    output logic            load_hit_o,
    output logic            master_hit_o
);

    logic load_class;
    logic master_class;

    always_comb begin
        load_class   = 1'b0;
        master_class = 1'b0;
        case (op_i)
            OP_W'(16'h0000), OP_W'(16'h000A), OP_W'(16'h000C),
            OP_W'(16'h000E), OP_W'(16'h0013): load_class = 1'b1;
            OP_W'(16'h0023), OP_W'(16'h0027), OP_W'(16'h002A),
            OP_W'(16'h002C), OP_W'(16'h0065), OP_W'(16'h0071): master_class = 1'b1;
            default: ;
        endcase
    end

    assign load_hit_o   = vld_i & load_class;
    assign master_hit_o = vld_i & master_class;

endmodule

// File: rtl/irq_src_bit.sv
module irq_src_bit (
    input  logic q_i,
    input  logic set_i,
    input  logic clr_i,
    output logic d_o
);

    // a set in the same cycle as a clear keeps the bit high
    always_comb begin
        if (set_i)      d_o = 1'b1;
        else if (clr_i) d_o = 1'b0;
        else            d_o = q_i;
    end

endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive (
    input  logic int_i,
    input  logic pol_i,
    output logic pin_o
);

    // asserted level equals pol_i, idle level is its inverse
    assign pin_o = int_i ? pol_i : ~pol_i;

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_evt_i,
    input  logic             cmd_done_vld_i,
    input  logic [OP_W-1:0]  cmd_done_op_i,
    input  logic             reg_wr_en_i,
    input  logic [REG_W-1:0] reg_wr_data_i,
    input  logic             cmd_wr_i,
    input  logic             auto_mode_i,
    input  logic             pol_i,
    input  logic             cold_rst_i,
    input  logic             warm_rst_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             int_pin_o
);

    irq_state_t st_d, st_q;

    logic            load_hit;
    logic            master_hit;
    logic            auto_clr;
    logic [NSRC-1:0] src_set;
    logic [NSRC-1:0] src_clr;
    logic [NSRC-1:0] src_nxt;
    logic            int_set;
    logic            int_clr;
    logic            int_nxt;

    irq_cmd_decode u_dec (
        .vld_i       (cmd_done_vld_i),
        .op_i        (cmd_done_op_i),
        .load_hit_o  (load_hit),
        .master_hit_o(master_hit)
    );

    assign auto_clr = cmd_wr_i & auto_mode_i;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == SRC_RD) begin : g_rd
            assign src_set[i] = src_evt_i[i] | load_hit;
        end else begin : g_oth
            assign src_set[i] = src_evt_i[i];
        end
        assign src_clr[i] = auto_clr | (reg_wr_en_i & ~reg_wr_data_i[POS_SRC0 + i]);

        irq_src_bit u_bit (
            .q_i  (st_q.src[i]),
            .set_i(src_set[i]),
            .clr_i(src_clr[i]),
            .d_o  (src_nxt[i])
        );
    end

    assign int_set = (|src_set) | master_hit;
    assign int_clr = auto_clr | (reg_wr_en_i & ~reg_wr_data_i[POS_INT]);

    irq_src_bit u_int_bit (
        .q_i  (st_q.int_b),
        .set_i(int_set),
        .clr_i(int_clr),
        .d_o  (int_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (cold_rst_i) begin
            st_d = COLD_DEF;
        end else if (warm_rst_i) begin
            st_d = WARM_DEF;
        end else begin
            st_d.int_b = int_nxt;
            st_d.src   = src_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= COLD_DEF;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data_o = '0;
        rd_data_o[POS_INT] = st_q.int_b;
        rd_data_o[POS_SRC0 +: NSRC] = st_q.src;
    end

    irq_pin_drive u_pin (
        .int_i(st_q.int_b),
        .pol_i(pol_i),
        .pin_o(int_pin_o)
    );

endmodule

// File: rtl/irq_status_reg_chk.sv
module irq_status_reg_chk
    import irq_status_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  src_evt_i,
    input logic             cmd_done_vld_i,
    input logic             cmd_wr_i,
    input logic             auto_mode_i,
    input logic             pol_i,
    input logic             cold_rst_i,
    input logic             warm_rst_i,
    input logic [REG_W-1:0] rd_data_o,
    input logic             int_pin_o
);

    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o & 16'h7F0F) == 16'h0000);

    assert_pin_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int_pin_o == (rd_data_o[15] ? pol_i : ~pol_i));

    assert_cold_default_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cold_rst_i |=> rd_data_o == 16'h8080);

    assert_warm_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_rst_i && !cold_rst_i) |=> rd_data_o == 16'h8010);

    assert_rd_src_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt_i[3] && !cold_rst_i && !warm_rst_i) |=> (rd_data_o[7] && rd_data_o[15]));

    assert_auto_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && auto_mode_i && src_evt_i == '0 && !cmd_done_vld_i
         && !cold_rst_i && !warm_rst_i) |=> rd_data_o == 16'h0000);

endmodule

bind irq_status_reg irq_status_reg_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_evt_i     (src_evt_i),
    .cmd_done_vld_i(cmd_done_vld_i),
    .cmd_wr_i      (cmd_wr_i),
    .auto_mode_i   (auto_mode_i),
    .pol_i         (pol_i),
    .cold_rst_i    (cold_rst_i),
    .warm_rst_i    (warm_rst_i),
    .rd_data_o     (rd_data_o),
    .int_pin_o     (int_pin_o)
);

// File: tb/irq_status_reg_bench.sv
module irq_status_reg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_evt_i = '0;
    logic        cmd_done_vld_i = 1'b0;
    logic [15:0] cmd_done_op_i = '0;
    logic        reg_wr_en_i = 1'b0;
    logic [15:0] reg_wr_data_i = '0;
    logic        cmd_wr_i = 1'b0;
    logic        auto_mode_i = 1'b0;
    logic        pol_i = 1'b1;
    logic        cold_rst_i = 1'b0;
    logic        warm_rst_i = 1'b0;
    logic [15:0] rd_data_o;
    logic        int_pin_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    irq_status_reg u_irq_status_reg (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        src_evt_i = '0; cmd_done_vld_i = 1'b0; reg_wr_en_i = 1'b0;
        cmd_wr_i = 1'b0; cold_rst_i = 1'b0; warm_rst_i = 1'b0;
    endtask

    // one clock; inputs set beforehand are sampled, outputs read after edge
    task automatic step();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic clear_all();
        reg_wr_en_i = 1'b1; reg_wr_data_i = 16'h0000; step();
    endtask

    task automatic t_reset();
        check("R1 por", rd_data_o, 16'h8080);
        clear_all();
        cold_rst_i = 1'b1; step();
        check("R1 cold", rd_data_o, 16'h8080);
    endtask

    task automatic t_warm();
        clear_all();
        warm_rst_i = 1'b1; step();
        check("R2 warm", rd_data_o, 16'h8010);
        warm_rst_i = 1'b1; cold_rst_i = 1'b1; step();
        check("R2 both", rd_data_o, 16'h8080);
    endtask

    task automatic t_sources();
        for (int i = 0; i < 4; i++) begin
            clear_all();
            src_evt_i = 4'b0001 << i; step();
            check("R3 src", rd_data_o, 16'h8000 | (16'h0010 << i));
        end
    endtask

    task automatic t_opcodes();
        logic [15:0] ld [5] = '{16'h0000, 16'h000A, 16'h000C, 16'h000E, 16'h0013};
        logic [15:0] ms [6] = '{16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0065, 16'h0071};
        logic [15:0] ot [4] = '{16'h000B, 16'h0024, 16'h0066, 16'hFFFF};
        foreach (ld[i]) begin
            clear_all();
            cmd_done_vld_i = 1'b1; cmd_done_op_i = ld[i]; step();
            check("R4 load op", rd_data_o, 16'h8080);
        end
        foreach (ms[i]) begin
            clear_all();
            cmd_done_vld_i = 1'b1; cmd_done_op_i = ms[i]; step();
            check("R5 master op", rd_data_o, 16'h8000);
        end
        foreach (ot[i]) begin
            clear_all();
            cmd_done_vld_i = 1'b1; cmd_done_op_i = ot[i]; step();
            check("R5 other op", rd_data_o, 16'h0000);
        end
        clear_all();
        cmd_done_vld_i = 1'b0; cmd_done_op_i = 16'h0065; step();
        check("R5 no valid", rd_data_o, 16'h0000);
    endtask

    task automatic t_sw_write();
        clear_all();
        src_evt_i = 4'b1111; step();
        check("R6 all set", rd_data_o, 16'h80F0);
        reg_wr_en_i = 1'b1; reg_wr_data_i = 16'hFFFF; step();
        check("R6 write ones", rd_data_o, 16'h80F0);
        reg_wr_en_i = 1'b1; reg_wr_data_i = 16'h80A0; step();
        check("R6 write zero", rd_data_o, 16'h80A0);
        reg_wr_en_i = 1'b1; reg_wr_data_i = 16'h00FF; step();
        check("R6 int clear", rd_data_o, 16'h00A0);
    endtask

    task automatic t_auto();
        clear_all();
        src_evt_i = 4'b0110; step();
        auto_mode_i = 1'b0; cmd_wr_i = 1'b1; step();
        check("R7 auto off", rd_data_o, 16'h8060);
        auto_mode_i = 1'b1; cmd_wr_i = 1'b1; step();
        check("R7 auto on", rd_data_o, 16'h0000);
        auto_mode_i = 1'b0;
    endtask

    task automatic t_set_wins();
        clear_all();
        reg_wr_en_i = 1'b1; reg_wr_data_i = 16'h0000; src_evt_i = 4'b1000; step();
        check("R8 write vs set", rd_data_o, 16'h8080);
        auto_mode_i = 1'b1; cmd_wr_i = 1'b1; src_evt_i = 4'b0100; step();
        check("R8 auto vs set", rd_data_o, 16'h8040);
        auto_mode_i = 1'b1; cmd_wr_i = 1'b1; cmd_done_vld_i = 1'b1;
        cmd_done_op_i = 16'h0071; step();
        check("R8 auto vs op", rd_data_o, 16'h8000);
        auto_mode_i = 1'b0;
    endtask

    task automatic t_pin();
        clear_all();
        pol_i = 1'b1; #1;
        check("R9 idle pol1", {15'b0, int_pin_o}, 16'h0000);
        pol_i = 1'b0; #1;
        check("R9 idle pol0", {15'b0, int_pin_o}, 16'h0001);
        src_evt_i = 4'b0001; step();
        check("R9 active pol0", {15'b0, int_pin_o}, 16'h0000);
        pol_i = 1'b1; #1;
        check("R9 active pol1", {15'b0, int_pin_o}, 16'h0001);
    endtask

    task automatic t_rst_prio();
        clear_all();
        warm_rst_i = 1'b1; src_evt_i = 4'b1110; reg_wr_en_i = 1'b1;
        reg_wr_data_i = 16'h0000; step();
        check("R10 warm wins", rd_data_o, 16'h8010);
        cold_rst_i = 1'b1; auto_mode_i = 1'b1; cmd_wr_i = 1'b1;
        cmd_done_vld_i = 1'b1; cmd_done_op_i = 16'h0023; step();
        check("R10 cold wins", rd_data_o, 16'h8080);
        auto_mode_i = 1'b0;
    endtask

    initial begin
        #20 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_warm();
        t_sources();
        t_opcodes();
        t_sw_write();
        t_auto();
        t_set_wins();
        t_pin();
        t_rst_prio();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule